// File: doc/BRIEF.md
# Transmit Break and Flow-Control Sequencer

This controller decides, cycle by cycle, what a serial transmitter's shift register takes next. It sits between a transmit FIFO and the shifter. The options are a FIFO character, an inserted flow-control character (Xon or Xoff), a forced break, or nothing. A host may pause FIFO traffic without stopping flow-control traffic. A queued flow character may be withdrawn until the moment it is handed to the shifter. A break is started only once the transmitter has drained completely, and after a break the line is held marking for a programmable number of bit times before new data leaves.

The FIFO storage, the shifter and baud generation live outside the block. The block receives the FIFO empty flag and its write strobe, the shifter's busy and end-of-stop-bit indications, and a one-cycle bit-time tick. It returns a one-cycle load strobe with a source code, a line-low force and the transmitter-idle status. All commands are one-cycle strobes.

Top module: `tx_flow_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `load_req`, `brk_force` and `tx_idle` are 0. Pause, break and pending flow character start cleared.
- R2: When the shifter is free (not busy, or signalling the end of its stop bit) and no load was issued in the previous cycle, one pending FIFO character is requested. `load_req` lasts exactly one cycle. `load_src` encodes 2'b00 = FIFO, 2'b01 = Xon, 2'b10 = Xoff, and 2'b11 never appears.
- R3: A pending flow character is loaded ahead of any FIFO character and is sent even while paused. If Xon and Xoff are requested in the same cycle, Xoff is kept.
- R4: A pause strobe stops further FIFO loads but does not disturb the character already in the shifter. A resume strobe lets FIFO loads continue.
- R5: A cancel strobe drops a pending flow character. It has no effect if that character is loaded in the same cycle or was loaded earlier.
- R6: A break-start strobe is ignored while `tx_en` is 0.
- R7: A requested break begins on a bit tick only after `tx_idle` is 1 and nothing is left to load. All FIFO characters are sent first, including ones written after the request. No load occurs while `brk_force` is 1.
- R8: After a break-stop strobe, `brk_force` falls on the next bit tick. No load is issued until `MARK_BITS` further bit ticks have passed.
- R9: `tx_idle` is 1 when enabled, with the shifter free, the FIFO empty and no flow character pending. It is 0 in the cycle after a FIFO write, a load, a reset strobe or a disable, and it stays 0 while a flow character is sent from underrun.
- R10: When `tx_en` drops, characters still in the FIFO continue to be loaded until it is empty.
- R11: A reset strobe clears pause, break (releasing the line at once) and any pending flow character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable level |
| fifo_empty | input | 1 | Transmit FIFO holds no character |
| fifo_wr | input | 1 | Host wrote a character to the FIFO this cycle |
| shf_busy | input | 1 | Shifter is sending a character |
| shf_done | input | 1 | Shifter is at the end of its stop bit |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| cmd_brk_start | input | 1 | Request a break |
| cmd_brk_stop | input | 1 | End or withdraw a break |
| cmd_xon | input | 1 | Queue an Xon character |
| cmd_xoff | input | 1 | Queue an Xoff character |
| cmd_pause | input | 1 | Host pause of FIFO traffic |
| cmd_resume | input | 1 | End host pause |
| cmd_cancel | input | 1 | Withdraw the queued flow character |
| cmd_reset | input | 1 | Transmitter reset strobe |
| load_req | output | 1 | Shifter load strobe |
| load_src | output | 2 | Source of the loaded character |
| brk_force | output | 1 | Hold the serial line low |
| tx_idle | output | 1 | Transmitter underrun status |

## Verification
The collision that matters is a cancel strobe arriving in the very cycle the queued Xoff is being loaded. The bench waits until it sees the Xoff load strobe on the port and then raises cancel for that same edge. It expects the Xoff to be counted as sent, and it compares this with an earlier cancel that must suppress the character. A second overlap is a flow request and a waiting FIFO character that both become eligible when the shifter frees. Here the bench requires the first load after the free-up to carry the Xon code.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

   localparam int SRC_W = 2;

   typedef enum logic [SRC_W-1:0] {
      SRC_FIFO = 2'b00,
      SRC_XON  = 2'b01,
      SRC_XOFF = 2'b10
   } tx_src_e;

   typedef enum logic [2:0] {
      BRK_OFF,
      BRK_WAIT,
      BRK_ON,
      BRK_STOP,
      BRK_MARK
   } brk_st_e;

endpackage

// File: rtl/tx_flow_slot.sv
module tx_flow_slot #(
   parameter bit XOFF_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_xon,
   input  logic req_xoff,
   input  logic cancel,
   input  logic clr,
   input  logic taken,
   output logic pend,
   output logic sel_xoff
);

   logic new_req;
   logic new_xoff;

   assign new_req = req_xon | req_xoff;

   generate
      if (XOFF_WINS) begin : g_xoff_first
         assign new_xoff = req_xoff;
      end else begin : g_xon_first
         assign new_xoff = req_xoff & ~req_xon;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         sel_xoff <= 1'b0;
      end else if (clr) begin
         pend     <= 1'b0;
         sel_xoff <= 1'b0;
      end else if (new_req) begin
         pend     <= 1'b1;
         sel_xoff <= new_xoff;
      end else if (taken || cancel) begin
         // a load in this cycle has already handed the character off
         pend     <= 1'b0;
      end
   end

endmodule

// File: rtl/tx_brk_ctl.sv
module tx_brk_ctl
   import tx_seq_pkg::*;
#(
   parameter int MARK_BITS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   input  logic clr,
   input  logic tx_en,
   input  logic tx_idle,
   input  logic quiet,
   input  logic bit_tick,
   output logic brk_force,
   output logic hold
);

   localparam int CNT_W = (MARK_BITS > 1) ? $clog2(MARK_BITS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MARK_BITS - 1);

   initial begin
      assert (MARK_BITS >= 1) else $error("MARK_BITS must be at least 1");
   end

   brk_st_e st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= BRK_OFF;
         cnt_q <= '0;
      end else if (clr) begin
         st_q  <= BRK_OFF;
         cnt_q <= '0;
      end else begin
         case (st_q)
            BRK_OFF:  if (start && !stop && tx_en) st_q <= BRK_WAIT;
            BRK_WAIT: begin
               if (stop)                                st_q <= BRK_OFF;
               else if (bit_tick && tx_idle && quiet)   st_q <= BRK_ON;
            end
            BRK_ON:   if (stop) st_q <= BRK_STOP;
            BRK_STOP: begin
               if (bit_tick) begin
                  st_q  <= BRK_MARK;
                  cnt_q <= '0;
               end
            end
            BRK_MARK: begin
               if (bit_tick) begin
                  if (cnt_q == CNT_LAST) st_q  <= BRK_OFF;
                  else                   cnt_q <= cnt_q + 1'b1;
               end
            end
            default:  st_q <= BRK_OFF;
         endcase
      end
   end

   assign brk_force = (st_q == BRK_ON) || (st_q == BRK_STOP);
   assign hold      = brk_force || (st_q == BRK_MARK);

endmodule

// File: rtl/tx_load_arb.sv
module tx_load_arb
   import tx_seq_pkg::*;
(
   input  logic             shf_busy,
   input  logic             shf_done,
   input  logic             ld_q,
   input  logic             hold,
   input  logic             fifo_empty,
   input  logic             can_fifo,
   input  logic             flow_pend,
   input  logic             flow_xoff,
   output logic             load_req,
   output logic [SRC_W-1:0] load_src,
   output logic             take_flow,
   output logic             quiet
);

   logic free;
   logic go;
   logic take_fifo;

   assign free      = !shf_busy || shf_done;
   assign go        = free && !ld_q && !hold;
   assign take_flow = go && flow_pend;
   assign take_fifo = go && !flow_pend && can_fifo && !fifo_empty;
   assign load_req  = take_flow || take_fifo;
   assign quiet     = !shf_busy && !ld_q && fifo_empty && !flow_pend;

   always_comb begin
      load_src = SRC_FIFO;
      if (take_flow) load_src = flow_xoff ? SRC_XOFF : SRC_XON;
   end

endmodule

// File: rtl/tx_flow_seq.sv
module tx_flow_seq
   import tx_seq_pkg::*;
#(
   parameter int MARK_BITS = 1,
   parameter bit XOFF_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             fifo_empty,
   input  logic             fifo_wr,
   input  logic             shf_busy,
   input  logic             shf_done,
   input  logic             bit_tick,
   input  logic             cmd_brk_start,
   input  logic             cmd_brk_stop,
   input  logic             cmd_xon,
   input  logic             cmd_xoff,
   input  logic             cmd_pause,
   input  logic             cmd_resume,
   input  logic             cmd_cancel,
   input  logic             cmd_reset,
   output logic             load_req,
   output logic [SRC_W-1:0] load_src,
   output logic             brk_force,
   output logic             tx_idle
);

   logic paused_q;
   logic act_q;
   logic ld_q;
   logic idle_q;
   logic flow_pend;
   logic flow_xoff;
   logic take_flow;
   logic quiet;
   logic hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paused_q <= 1'b0;
         act_q    <= 1'b0;
         ld_q     <= 1'b0;
         idle_q   <= 1'b0;
      end else begin
         if (cmd_reset || cmd_resume) paused_q <= 1'b0;
         else if (cmd_pause)          paused_q <= 1'b1;
         // stays active after disable until the FIFO has drained
         act_q  <= tx_en || (act_q && !fifo_empty);
         ld_q   <= load_req;
         idle_q <= tx_en && quiet && !load_req && !fifo_wr && !cmd_reset;
      end
   end

   tx_flow_slot #(.XOFF_WINS(XOFF_WINS)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_xon  (cmd_xon),
      .req_xoff (cmd_xoff),
      .cancel   (cmd_cancel),
      .clr      (cmd_reset),
      .taken    (take_flow),
      .pend     (flow_pend),
      .sel_xoff (flow_xoff)
   );

   tx_brk_ctl #(.MARK_BITS(MARK_BITS)) u_brk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_brk_start),
      .stop      (cmd_brk_stop),
      .clr       (cmd_reset),
      .tx_en     (tx_en),
      .tx_idle   (idle_q),
      .quiet     (quiet),
      .bit_tick  (bit_tick),
      .brk_force (brk_force),
      .hold      (hold)
   );

   tx_load_arb u_arb (
      .shf_busy   (shf_busy),
      .shf_done   (shf_done),
      .ld_q       (ld_q),
      .hold       (hold),
      .fifo_empty (fifo_empty),
      .can_fifo   (act_q && !paused_q),
      .flow_pend  (flow_pend),
      .flow_xoff  (flow_xoff),
      .load_req   (load_req),
      .load_src   (load_src),
      .take_flow  (take_flow),
      .quiet      (quiet)
   );

   assign tx_idle = idle_q;

endmodule

// File: rtl/tx_flow_seq_chk.sv
module tx_flow_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       load_req,
   input logic [1:0] load_src,
   input logic       brk_force,
   input logic       tx_idle,
   input logic       shf_busy,
   input logic       fifo_wr,
   input logic       cmd_reset,
   input logic       paused,
   input logic       flow_pend
);

   assert_src_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |-> load_src != 2'b11);

   assert_single_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |=> !load_req);

   assert_flow_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && flow_pend) |-> load_src != 2'b00);

   assert_pause_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && paused) |-> load_src != 2'b00);

   assert_brk_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_force) |-> !shf_busy);

   assert_no_load_in_brk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      brk_force |-> !load_req);

   assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr || load_req || cmd_reset) |=> !tx_idle);

   assert_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (!brk_force && !paused && !flow_pend));

endmodule

bind tx_flow_seq tx_flow_seq_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_req  (load_req),
   .load_src  (load_src),
   .brk_force (brk_force),
   .tx_idle   (tx_idle),
   .shf_busy  (shf_busy),
   .fifo_wr   (fifo_wr),
   .cmd_reset (cmd_reset),
   .paused    (paused_q),
   .flow_pend (flow_pend)
);

// File: tb/tx_flow_seq_tb_top.sv
module tx_flow_seq_tb_top;

   localparam int CHAR_CYC = 20;
   localparam int TICK_DIV = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0, fifo_wr = 1'b0, bit_tick;
   logic cmd_brk_start = 1'b0, cmd_brk_stop = 1'b0, cmd_xon = 1'b0, cmd_xoff = 1'b0;
   logic cmd_pause = 1'b0, cmd_resume = 1'b0, cmd_cancel = 1'b0, cmd_reset = 1'b0;
   logic load_req, brk_force, tx_idle;
   logic [1:0] load_src;
   logic shf_busy = 1'b0;
   logic shf_done;
   logic fifo_empty;

   int fifo_cnt = 0, shf_cnt = 0, tick_cnt = 0;
   int n_fifo = 0, n_xon = 0, n_xoff = 0, n_done = 0;
   int n_chk = 0, n_fail = 0;
   logic pause_m = 1'b0, rand_on = 1'b0, finished = 1'b0;

   always #2 clk = ~clk;

   tx_flow_seq dut_i (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fifo_empty(fifo_empty), .fifo_wr(fifo_wr),
      .shf_busy(shf_busy), .shf_done(shf_done), .bit_tick(bit_tick),
      .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop), .cmd_xon(cmd_xon),
      .cmd_xoff(cmd_xoff), .cmd_pause(cmd_pause), .cmd_resume(cmd_resume),
      .cmd_cancel(cmd_cancel), .cmd_reset(cmd_reset), .load_req(load_req),
      .load_src(load_src), .brk_force(brk_force), .tx_idle(tx_idle)
   );

   // environment: FIFO occupancy, shifter and bit tick
   assign fifo_empty = (fifo_cnt == 0);
   assign shf_done   = shf_busy && (shf_cnt == 1);
   assign bit_tick   = (tick_cnt == TICK_DIV - 1);

   always @(posedge clk) begin
      tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
      fifo_cnt <= fifo_cnt + (fifo_wr ? 1 : 0) - ((load_req && load_src == 2'b00) ? 1 : 0);
      if (load_req) begin
         shf_busy <= 1'b1;
         shf_cnt  <= CHAR_CYC;
         if (load_src == 2'b00) n_fifo <= n_fifo + 1;
         if (load_src == 2'b01) n_xon  <= n_xon + 1;
         if (load_src == 2'b10) n_xoff <= n_xoff + 1;
      end else if (shf_done) begin
         shf_busy <= 1'b0;
         shf_cnt  <= 0;
      end else if (shf_busy) begin
         shf_cnt <= shf_cnt - 1;
      end
      if (shf_done) n_done <= n_done + 1;
      if (cmd_reset || cmd_resume) pause_m <= 1'b0;
      else if (cmd_pause)          pause_m <= 1'b1;
   end

   function automatic bit fifo_load_allowed(input bit paused_now, input bit brk_now);
      return !paused_now && !brk_now;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // random-phase invariants, sampled mid-cycle
   always @(posedge clk) begin
      #2;
      if (rand_on && load_req) begin
         chk(load_src != 2'b00 || fifo_load_allowed(pause_m, brk_force),
             "R4/R7 fifo load while paused or in break", int'(load_src), 1);
      end
   end

   task automatic step(input int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr1();   fifo_wr = 1'b1; step(); fifo_wr = 1'b0; endtask
   task automatic wait_busy();
      for (int i = 0; i < 100; i++) begin step(); #1; if (shf_busy) break; end
   endtask
   task automatic wait_idle(input int maxc);
      for (int i = 0; i < maxc; i++) begin step(); #1; if (tx_idle) break; end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 0, 1);
         summary();
      end
   end

   initial begin
      int b0, b1, cyc, t_fall;
      void'($urandom(32'd7211));

      // R1: reset state
      step(3); #1;
      chk(!load_req && !brk_force && !tx_idle, "R1 outputs in reset",
          {load_req, brk_force, tx_idle}, 0);
      rst_n = 1'b1;
      step(); #1;
      chk(!load_req && !brk_force && !tx_idle, "R1 outputs after reset",
          {load_req, brk_force, tx_idle}, 0);

      // R9: idle once enabled with nothing to send
      tx_en = 1'b1;
      step(3); #1;
      chk(tx_idle == 1'b1, "R9 idle when enabled and empty", tx_idle, 1);

      // R2 + R9: three characters
      b0 = n_fifo;
      fifo_wr = 1'b1; step(); #1;
      chk(tx_idle == 1'b0, "R9 idle cleared after write", tx_idle, 0);
      step(2); fifo_wr = 1'b0;
      wait_idle(300);
      chk(n_fifo - b0 == 3, "R2 all FIFO characters loaded", n_fifo - b0, 3);
      chk(tx_idle == 1'b1, "R9 idle after last stop bit", tx_idle, 1);

      // R7: break waits for the FIFO, including later writes
      b0 = n_fifo;
      wr1();
      cmd_brk_start = 1'b1; step(); cmd_brk_start = 1'b0;
      wait_busy();
      wr1();
      for (int i = 0; i < 300; i++) begin
         step(); #1;
         if (brk_force) break;
         if (i > 2) chk(fifo_cnt != 0 || !brk_force, "R7 break before drain", fifo_cnt, 0);
      end
      chk(brk_force && n_fifo - b0 == 2, "R7 break after both characters",
          n_fifo - b0, 2);

      // R8: stop break, line released and mark held
      step(3);
      cmd_brk_stop = 1'b1; fifo_wr = 1'b1; step(); cmd_brk_stop = 1'b0; fifo_wr = 1'b0;
      cyc = 0;
      for (int i = 0; i < 40; i++) begin #1; if (!brk_force) break; cyc++; step(); end
      chk(cyc <= 2 * TICK_DIV, "R8 line released within two bit times", cyc, 2 * TICK_DIV);
      t_fall = 0;
      for (int i = 0; i < 60; i++) begin #1; if (load_req) break; t_fall++; step(); end
      chk(t_fall >= TICK_DIV, "R8 mark held one bit time", t_fall, TICK_DIV);
      wait_idle(200);

      // R7: break from an empty transmitter within two bit times
      cmd_brk_start = 1'b1; step(); cmd_brk_start = 1'b0;
      cyc = 0;
      for (int i = 0; i < 40; i++) begin #1; if (brk_force) break; cyc++; step(); end
      chk(brk_force && cyc <= 2 * TICK_DIV, "R7 break start latency", cyc, 2 * TICK_DIV);
      cmd_brk_stop = 1'b1; step(); cmd_brk_stop = 1'b0;
      step(40);

      // R6: break ignored while disabled
      tx_en = 1'b0; step();
      cmd_brk_start = 1'b1; step(); cmd_brk_start = 1'b0;
      b1 = 0;
      for (int i = 0; i < 40; i++) begin step(); #1; if (brk_force) b1 = 1; end
      chk(b1 == 0, "R6 break while disabled", b1, 0);
      tx_en = 1'b1;
      wait_idle(50);

      // R4 + R3: pause keeps current char, passes Xon, resume restarts
      b0 = n_fifo; b1 = n_done;
      wr1(); wait_busy();
      cmd_pause = 1'b1; step(); cmd_pause = 1'b0;
      wr1(); wr1();
      step(80); #1;
      chk(n_fifo - b0 == 1, "R4 no FIFO load while paused", n_fifo - b0, 1);
      chk(n_done - b1 == 1, "R4 current character completed", n_done - b1, 1);
      b1 = n_xon;
      cmd_xon = 1'b1; step(); cmd_xon = 1'b0;
      step(40); #1;
      chk(n_xon - b1 == 1, "R3 Xon sent while paused", n_xon - b1, 1);
      chk(fifo_cnt == 2, "R4 FIFO held during pause", fifo_cnt, 2);
      cmd_resume = 1'b1; step(); cmd_resume = 1'b0;
      wait_idle(300);
      chk(n_fifo - b0 == 3, "R4 resume restarts FIFO", n_fifo - b0, 3);

      // R5: cancel before load removes the Xoff
      b1 = n_xoff;
      wr1(); wait_busy();
      cmd_xoff = 1'b1; step(); cmd_xoff = 1'b0;
      cmd_cancel = 1'b1; step(); cmd_cancel = 1'b0;
      step(60); #1;
      chk(n_xoff - b1 == 0, "R5 cancelled Xoff not sent", n_xoff - b1, 0);
      // R5: cancel in the load cycle has no effect
      wr1(); wait_busy();
      cmd_xoff = 1'b1; step(); cmd_xoff = 1'b0;
      for (int i = 0; i < 60; i++) begin step(); #1; if (load_req && load_src == 2'b10) break; end
      cmd_cancel = 1'b1; step(); cmd_cancel = 1'b0;
      step(5); #1;
      chk(n_xoff - b1 == 1, "R5 cancel at load ignored", n_xoff - b1, 1);
      wait_idle(100);

      // R3: flow character beats a waiting FIFO character
      wr1(); wait_busy();
      fifo_wr = 1'b1; cmd_xon = 1'b1; step(); fifo_wr = 1'b0; cmd_xon = 1'b0;
      for (int i = 0; i < 60; i++) begin step(); #1; if (load_req) break; end
      chk(load_req && load_src == 2'b01, "R3 Xon ahead of FIFO", int'(load_src), 1);
      wait_idle(200);

      // R9: idle stays 0 while Xon goes out from underrun
      cmd_xon = 1'b1; step(); cmd_xon = 1'b0;
      wait_busy(); step(5); #1;
      chk(tx_idle == 1'b0, "R9 idle low during Xon", tx_idle, 0);
      wait_idle(100);
      chk(tx_idle == 1'b1, "R9 idle back after Xon", tx_idle, 1);

      // R10: disable still drains the FIFO
      wr1(); wr1(); tx_en = 1'b0;
      step(150); #1;
      chk(fifo_cnt == 0, "R10 FIFO drained after disable", fifo_cnt, 0);
      chk(tx_idle == 1'b0, "R9 idle low while disabled", tx_idle, 0);
      tx_en = 1'b1; wait_idle(50);

      // R11: reset strobe clears break, pause, pending flow
      cmd_brk_start = 1'b1; step(); cmd_brk_start = 1'b0;
      for (int i = 0; i < 40; i++) begin step(); #1; if (brk_force) break; end
      b1 = n_xoff;
      cmd_pause = 1'b1; cmd_xoff = 1'b1; step(); cmd_pause = 1'b0; cmd_xoff = 1'b0;
      cmd_reset = 1'b1; step(); cmd_reset = 1'b0; #1;
      chk(brk_force == 1'b0, "R11 break released by reset", brk_force, 0);
      step(30); #1;
      chk(n_xoff - b1 == 0, "R11 pending Xoff dropped", n_xoff - b1, 0);
      b0 = n_fifo;
      wr1(); step(40); #1;
      chk(n_fifo - b0 == 1, "R11 pause cleared by reset", n_fifo - b0, 1);
      wait_idle(100);

      // constrained random mix
      rand_on = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom % 64);
         cmd_pause     = (r == 0);
         cmd_resume    = (r == 1);
         cmd_xon       = (r == 2);
         cmd_xoff      = (r == 3);
         cmd_cancel    = (r == 4);
         cmd_brk_start = (r == 5);
         cmd_brk_stop  = (r == 6) || (r == 13);
         fifo_wr       = (r >= 7 && r <= 10);
         cmd_reset     = (r == 12);
         if (r == 11) tx_en = ~tx_en;
         step();
      end
      {cmd_pause, cmd_xon, cmd_xoff, cmd_cancel, cmd_brk_start, fifo_wr, cmd_reset} = '0;
      tx_en = 1'b1; cmd_resume = 1'b1; cmd_brk_stop = 1'b1; step();
      cmd_resume = 1'b0; cmd_brk_stop = 1'b0;
      step(5);
      cmd_brk_stop = 1'b1; step(); cmd_brk_stop = 1'b0;
      rand_on = 1'b0;
      for (int i = 0; i < 20000; i++) begin step(); #1; if (fifo_cnt == 0 && tx_idle) break; end
      chk(fifo_cnt == 0, "R2 random traffic fully drained", fifo_cnt, 0);
      chk(tx_idle == 1'b1 && !brk_force, "R9 idle after random traffic", tx_idle, 1);

      finished = 1'b1;
      summary();
   end

endmodule